// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block receives asynchronous start-stop characters from a serial line that idles high. The line is first passed through a resynchronizing flop chain. After that it is examined on every pulse of an external tick that runs at sixteen times the bit rate. A falling edge is only a candidate start bit. It is accepted if the line is still low half a bit later, and the same mid-bit point is then used to sample every following bit. Bits arrive least significant first and are shifted into a register. When the character is complete, it appears on a parallel output and a data-ready flag goes high.

The character format is set by static inputs: the data width (5 to 8 bits), the parity mode (none, odd or even) and the stop length the sender uses. The receiver reports four conditions alongside the data:
- a bad stop bit;
- a parity mismatch;
- a character lost because the previous one was never read;
- a line held at space for longer than a whole character.

The host acknowledges a character with a one-cycle read strobe.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, rx_data is 0 and rx_valid, err_frame, err_parity, err_overrun and brk_det are all 0.
- R2: A low level is taken as a start bit only if the line is still low 8 ticks after the falling edge was first seen. A shorter low pulse produces no character.
- R3: After a valid start, each bit is sampled 16 ticks after the previous sample and shifted in LSB first. When the character completes, rx_data shows it and rx_valid goes to 1.
- R4: cfg_bits selects the data width: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits of rx_data above the selected width read as 0.
- R5: cfg_par selects the parity mode: 0 means none, 1 means odd, 2 means even and 3 means none. With odd or even parity, one extra bit follows the data bits, and err_parity is 1 for a character whose parity bit makes the count of ones (data plus parity bit) differ from the selected mode. With no parity, err_parity is always 0.
- R6: If the line is low at the stop-bit sample point, err_frame is 1 for that character. The character is still delivered.
- R7: If a character completes while rx_valid is still 1, the new character replaces the old one and err_overrun goes to 1. It stays at 1 until a read strobe.
- R8: A read strobe clears rx_valid, err_overrun and brk_det.
- R9: brk_det goes to 1 once the line has been low for one full character time. A character time is (2 + data bits + parity bit + cfg_two_stop) × 16 ticks. brk_det stays at 1 until read. An all-zero 8-bit character with a valid stop bit does not set it. A break also delivers a zero character with err_frame set.
- R10: After a character with a low stop bit, the receiver waits for the line to return high before it hunts for another start bit. A line held low therefore yields exactly one character.
- R11: Only one stop bit is required, whatever cfg_two_stop is set to. A start bit may follow the first stop bit directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_bits | input | 2 | Data width select (5 to 8) |
| cfg_par | input | 2 | Parity mode select |
| cfg_two_stop | input | 1 | Sender uses two stop bits (affects break timing only) |
| rd_strobe | input | 1 | Host read acknowledge |
| rx_data | output | 8 | Received character, right aligned |
| rx_valid | output | 1 | Character ready |
| err_frame | output | 1 | Stop bit was low |
| err_parity | output | 1 | Parity mismatch |
| err_overrun | output | 1 | Unread character was overwritten |
| brk_det | output | 1 | Break seen on the line |

## Verification
The bench sends a low pulse shorter than half a bit. A receiver that does not check the start at mid-bit would accept this pulse and deliver a spurious character. It holds the line low for several character times. A receiver that resumes hunting at once would then deliver a stream of zero characters, and that stream shows up as an overrun. It sends an all-zero 8-bit character with a good stop bit. A break threshold that is too short would set brk_det on that character. It also sends a 5-bit character after an 8-bit one, so that stale upper bits left in the shift register would show through. Finally, it sends frames back to back with a single stop bit while two stop bits are configured, which catches a receiver that insists on the longer stop.

// File: rtl/srx_pkg.sv
package srx_pkg;
   localparam int unsigned DATA_MAX = 8;

   typedef enum logic [2:0] {
      ST_WAIT_IDLE,
      ST_HUNT,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } rx_state_e;

   typedef struct packed {
      logic [DATA_MAX-1:0] data;
      logic                frame_err;
      logic                par_err;
   } rx_char_t;

   // parity bit a correct sender would place after the data
   function automatic logic par_expect(logic [DATA_MAX-1:0] d, logic odd);
      return (^d) ^ odd;
   endfunction
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("srx_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], din};
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
   import srx_pkg::*;
#(
   parameter int unsigned OVERSAMPLE = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       line,
   input  logic [1:0] cfg_bits,
   input  logic       par_active,
   input  logic       par_odd,
   output logic       char_done,
   output rx_char_t   char_out
);
   localparam int unsigned CNT_W = $clog2(OVERSAMPLE);
   localparam int unsigned HALF  = OVERSAMPLE / 2;
   localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(HALF - 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OVERSAMPLE - 1);

   rx_state_e            state;
   logic [CNT_W-1:0]     cnt;
   logic [3:0]           bidx;
   logic [DATA_MAX-1:0]  shreg;
   logic                 par_bit;
   logic [3:0]           nbits;
   logic [DATA_MAX-1:0]  aligned;

   assign nbits   = 4'd5 + {2'b00, cfg_bits};
   assign aligned = shreg >> (4'd8 - nbits);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_WAIT_IDLE;
         cnt       <= '0;
         bidx      <= '0;
         shreg     <= '0;
         par_bit   <= 1'b0;
         char_done <= 1'b0;
         char_out  <= '0;
      end else begin
         char_done <= 1'b0;
         unique case (state)
            ST_WAIT_IDLE: begin
               if (line) state <= ST_HUNT;
            end
            ST_HUNT: begin
               if (tick && !line) begin
                  state <= ST_START;
                  cnt   <= '0;
               end
            end
            ST_START: begin
               if (tick) begin
                  if (cnt == CNT_HALF) begin
                     cnt  <= '0;
                     bidx <= '0;
                     state <= line ? ST_HUNT : ST_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            ST_DATA: begin
               if (tick) begin
                  if (cnt == CNT_FULL) begin
                     cnt   <= '0;
                     shreg <= {line, shreg[DATA_MAX-1:1]};
                     bidx  <= bidx + 1'b1;
                     if (bidx == nbits - 1'b1)
                        state <= par_active ? ST_PAR : ST_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            ST_PAR: begin
               if (tick) begin
                  if (cnt == CNT_FULL) begin
                     cnt     <= '0;
                     par_bit <= line;
                     state   <= ST_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            ST_STOP: begin
               if (tick) begin
                  if (cnt == CNT_FULL) begin
                     cnt                <= '0;
                     char_done          <= 1'b1;
                     char_out.data      <= aligned;
                     char_out.frame_err <= !line;
                     char_out.par_err   <= par_active &&
                                           (par_bit != par_expect(aligned, par_odd));
                     state              <= line ? ST_HUNT : ST_WAIT_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            default: state <= ST_WAIT_IDLE;
         endcase
      end
   end

   AST_START_LOW_AT_MID: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_START && state == ST_DATA) |-> $past(!line)); // R2
   AST_BIDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DATA) |-> (bidx < nbits)); // R4
   AST_IDLE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT_IDLE && !line) |=> (state == ST_WAIT_IDLE)); // R10
endmodule

// File: rtl/srx_break.sv
module srx_break
   import srx_pkg::*;
#(
   parameter int unsigned OVERSAMPLE = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       line,
   input  logic [1:0] cfg_bits,
   input  logic       par_active,
   input  logic       two_stop,
   input  logic       clr,
   output logic       brk
);
   localparam int unsigned MAX_TICKS = OVERSAMPLE * (DATA_MAX + 4);
   localparam int unsigned LW        = $clog2(MAX_TICKS + 1);

   logic [3:0]    frame_bits;
   logic [LW-1:0] thr;
   logic [LW-1:0] low_cnt;

   assign frame_bits = 4'd7 + {2'b00, cfg_bits} + {3'b000, par_active} + {3'b000, two_stop};
   assign thr        = LW'(int'(frame_bits) * OVERSAMPLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt <= '0;
         brk     <= 1'b0;
      end else begin
         if (line)
            low_cnt <= '0;
         else if (tick && low_cnt != thr)
            low_cnt <= low_cnt + 1'b1;

         if (tick && !line && low_cnt == thr - 1'b1)
            brk <= 1'b1;
         else if (clr)
            brk <= 1'b0;
      end
   end

   AST_BRK_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brk) |-> $past(!line)); // R9
   AST_BRK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (brk && !clr) |=> brk); // R9
endmodule

// File: rtl/srx_holding.sv
module srx_holding
   import srx_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                char_done,
   input  rx_char_t            char_in,
   input  logic                rd,
   input  logic                par_active,
   output logic [DATA_MAX-1:0] data,
   output logic                valid,
   output logic                fe,
   output logic                pe,
   output logic                ovr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data  <= '0;
         valid <= 1'b0;
         fe    <= 1'b0;
         pe    <= 1'b0;
         ovr   <= 1'b0;
      end else if (char_done) begin
         data  <= char_in.data;
         fe    <= char_in.frame_err;
         pe    <= char_in.par_err;
         valid <= 1'b1;
         ovr   <= (ovr || valid) && !rd;
      end else if (rd) begin
         valid <= 1'b0;
         ovr   <= 1'b0;
      end
   end

   AST_DONE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      char_done |=> valid); // R3
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !char_done) |=> (!valid && !ovr)); // R8
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !rd) |=> ovr); // R7
   AST_NO_PE_WITHOUT_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
      (char_done && !par_active) |=> !pe); // R5
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
   import srx_pkg::*;
#(
   parameter int unsigned OVERSAMPLE  = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          PARITY_EN   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick16,
   input  logic                rxd,
   input  logic [1:0]          cfg_bits,
   input  logic [1:0]          cfg_par,
   input  logic                cfg_two_stop,
   input  logic                rd_strobe,
   output logic [DATA_MAX-1:0] rx_data,
   output logic                rx_valid,
   output logic                err_frame,
   output logic                err_parity,
   output logic                err_overrun,
   output logic                brk_det
);
   generate
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_osr
         $error("serial_rx_core: OVERSAMPLE must be even and at least 4");
      end
   endgenerate

   logic     line_s;
   logic     par_active;
   logic     par_odd;
   logic     char_done;
   rx_char_t char_w;

   generate
      if (PARITY_EN) begin : g_par
         assign par_active = (cfg_par == 2'b01) || (cfg_par == 2'b10);
         assign par_odd    = (cfg_par == 2'b01);
      end else begin : g_nopar
         logic unused_par_cfg;
         assign unused_par_cfg = ^cfg_par;
         assign par_active     = 1'b0;
         assign par_odd        = 1'b0;
      end
   endgenerate

   srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rxd),
      .dout (line_s)
   );

   srx_framer #(.OVERSAMPLE(OVERSAMPLE)) u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick16),
      .line      (line_s),
      .cfg_bits  (cfg_bits),
      .par_active(par_active),
      .par_odd   (par_odd),
      .char_done (char_done),
      .char_out  (char_w)
   );

   srx_break #(.OVERSAMPLE(OVERSAMPLE)) u_break (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick16),
      .line      (line_s),
      .cfg_bits  (cfg_bits),
      .par_active(par_active),
      .two_stop  (cfg_two_stop),
      .clr       (rd_strobe),
      .brk       (brk_det)
   );

   srx_holding u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .char_done (char_done),
      .char_in   (char_w),
      .rd        (rd_strobe),
      .par_active(par_active),
      .data      (rx_data),
      .valid     (rx_valid),
      .fe        (err_frame),
      .pe        (err_parity),
      .ovr       (err_overrun)
   );

   AST_PE_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_parity) |-> $past(par_active)); // R5
endmodule

// File: tb/tb_serial_rx_core.sv
module tb_serial_rx_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic       rxd = 1'b1;
   logic [1:0] cfg_bits = 2'd3;
   logic [1:0] cfg_par = 2'd0;
   logic       cfg_two_stop = 1'b0;
   logic       rd_strobe = 1'b0;
   logic [7:0] rx_data;
   logic       rx_valid, err_frame, err_parity, err_overrun, brk_det;

   int n_chk = 0;
   int n_bad = 0;
   bit done_flag = 0;
   logic [1:0] tdiv = '0;

   serial_rx_core dut (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
      .cfg_bits(cfg_bits), .cfg_par(cfg_par), .cfg_two_stop(cfg_two_stop),
      .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_valid(rx_valid),
      .err_frame(err_frame), .err_parity(err_parity),
      .err_overrun(err_overrun), .brk_det(brk_det)
   );

   always #10 clk = ~clk;

   always @(negedge clk) begin
      tdiv   <= tdiv + 1'b1;
      tick16 <= (tdiv == 2'd3);
   end

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wait_ticks(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         while (!tick16) @(posedge clk);
      end
   endtask

   task automatic hold(logic v, int n);
      @(negedge clk);
      rxd = v;
      wait_ticks(n);
   endtask

   task automatic host_read();
      @(negedge clk); rd_strobe = 1'b1;
      @(negedge clk); rd_strobe = 1'b0;
   endtask

   // par: 0 none, 1 odd, 2 even
   task automatic send(logic [7:0] d, int nb, int par, bit bad_par, logic stop_v);
      logic pb;
      pb = ^(d & 8'((1 << nb) - 1));
      if (par == 1) pb = ~pb;
      hold(1'b0, 16);
      for (int i = 0; i < nb; i++) hold(d[i], 16);
      if (par != 0) hold(pb ^ bad_par, 16);
      hold(stop_v, 16);
      if (!stop_v) hold(1'b1, 16);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 data", rx_data, 0);
      chk("R1 valid", rx_valid, 0);
      chk("R1 flags", {err_frame, err_parity, err_overrun, brk_det}, 0);
   endtask

   task automatic t_basic();
      cfg_bits = 2'd3; cfg_par = 2'd0;
      send(8'hA5, 8, 0, 0, 1'b1);
      chk("R3 data", rx_data, 8'hA5);
      chk("R3 valid", rx_valid, 1);
      chk("R3 errors", {err_frame, err_parity}, 0);
      host_read();
      chk("R8 valid cleared", rx_valid, 0);
      send(8'h00, 8, 0, 0, 1'b1);
      chk("R9 zero char data", rx_data, 0);
      chk("R9 no break on zero char", brk_det, 0);
      chk("R6 zero char no frame err", err_frame, 0);
      host_read();
   endtask

   task automatic t_width();
      send(8'hFF, 8, 0, 0, 1'b1);
      host_read();
      cfg_bits = 2'd0;
      send(8'h1B, 5, 0, 0, 1'b1);
      chk("R4 five bits", rx_data, 8'h1B);
      host_read();
      cfg_bits = 2'd2; cfg_par = 2'd2;
      send(8'h5B, 7, 2, 0, 1'b1);
      chk("R4 seven bits", rx_data, 8'h5B);
      chk("R5 even ok", err_parity, 0);
      host_read();
      cfg_bits = 2'd3;
   endtask

   task automatic t_parity();
      cfg_par = 2'd1;
      send(8'h3C, 8, 1, 0, 1'b1);
      chk("R5 odd ok", err_parity, 0);
      host_read();
      send(8'h3C, 8, 1, 1, 1'b1);
      chk("R5 odd bad", err_parity, 1);
      chk("R5 odd bad data", rx_data, 8'h3C);
      host_read();
      cfg_par = 2'd2;
      send(8'h81, 8, 2, 1, 1'b1);
      chk("R5 even bad", err_parity, 1);
      host_read();
      cfg_par = 2'd3;
      send(8'h81, 8, 0, 0, 1'b1);
      chk("R5 mode 3 none", err_parity, 0);
      chk("R5 mode 3 data", rx_data, 8'h81);
      host_read();
      cfg_par = 2'd0;
   endtask

   task automatic t_frame();
      send(8'h6E, 8, 0, 0, 1'b0);
      chk("R6 frame err", err_frame, 1);
      chk("R6 data kept", rx_data, 8'h6E);
      host_read();
      send(8'h11, 8, 0, 0, 1'b1);
      chk("R6 next ok", err_frame, 0);
      host_read();
   endtask

   task automatic t_overrun();
      send(8'h12, 8, 0, 0, 1'b1);
      send(8'h34, 8, 0, 0, 1'b1);
      chk("R7 replaced", rx_data, 8'h34);
      chk("R7 overrun", err_overrun, 1);
      wait_ticks(10);
      chk("R7 sticky", err_overrun, 1);
      host_read();
      chk("R8 overrun cleared", err_overrun, 0);
      chk("R8 valid cleared", rx_valid, 0);
   endtask

   task automatic t_glitch();
      hold(1'b0, 3);
      hold(1'b1, 40);
      chk("R2 glitch ignored", rx_valid, 0);
      send(8'hC7, 8, 0, 0, 1'b1);
      chk("R2 after glitch", rx_data, 8'hC7);
      host_read();
   endtask

   task automatic t_break();
      hold(1'b0, 16 * 30);
      chk("R9 break", brk_det, 1);
      chk("R9 zero char", rx_data, 0);
      chk("R9 frame err", err_frame, 1);
      chk("R10 single char", err_overrun, 0);
      chk("R10 valid", rx_valid, 1);
      host_read();
      chk("R8 break cleared", brk_det, 0);
      hold(1'b1, 32);
      send(8'h96, 8, 0, 0, 1'b1);
      chk("R10 resume", rx_data, 8'h96);
      chk("R10 no frame err", err_frame, 0);
      host_read();
   endtask

   task automatic t_one_stop();
      cfg_two_stop = 1'b1;
      send(8'h5A, 8, 0, 0, 1'b1);
      chk("R11 first", rx_data, 8'h5A);
      host_read();
      send(8'hC3, 8, 0, 0, 1'b1);
      chk("R11 second", rx_data, 8'hC3);
      chk("R11 no frame err", err_frame, 0);
      chk("R11 no overrun", err_overrun, 0);
      host_read();
      cfg_two_stop = 1'b0;
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      hold(1'b1, 20);
      t_basic();
      t_width();
      t_parity();
      t_frame();
      t_overrun();
      t_glitch();
      t_break();
      t_one_stop();
      finish_run();
   end

   initial begin
      #(20 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule